// File: doc/BRIEF.md
# Two-Wire Clock-Control Register Slave

This block is a slave on a two-wire SMBus-style management bus. It keeps a small bank of byte-wide clock-control registers, and it shows their contents in parallel to the clock-selection and spread-modulation logic next to it. The serial clock and data lines are oversampled by the system clock. The slave recognises start and stop conditions, matches one fixed device address, and acknowledges each byte it accepts by pulling the data line low through an open-drain enable output.

There is no register pointer. A write sends the address, then one command byte and one byte-count byte. The slave acknowledges both and ignores their contents. The data bytes that follow fill register 0, register 1 and so on. A read uses the neighbouring address. The slave then returns a count byte, followed by the registers starting at register 0, until the master stops acknowledging. The system clock must run at least ten times faster than the serial clock.

Top module: `smb_ctl_slave`

## Requirements
- R1: After reset, register 0 is 0x07, register 1 is 0xFF, register 2 is 0xFE and every other register is 0x00. Register k appears on `regs_o[8k+7:8k]`, and the data line is released (`sda_oe` = 0).
- R2: A stop condition (data rising while the clock is high) or a start condition (data falling while the clock is high) returns the slave to its idle or address-receive state at any point, and releases the line. A new write after either condition fills the registers again from register 0.
- R3: The address byte 0xD2 (seven-bit address 0x69 with the direction bit 0) is acknowledged. The next two bytes are acknowledged and have no effect on any register.
- R4: Any address byte other than 0xD2 or 0xD3 gets no acknowledge. The slave then stays silent until the next start or stop, and the registers keep their values.
- R5: Bits are received MSB first. In a write, the k-th data byte (counting from 0) is acknowledged and stored in register k.
- R6: At most 10 data bytes are accepted per write. Data bytes numbered from the register count up to the tenth are acknowledged and discarded. The eleventh and every later data byte are not acknowledged, and the slave stays silent.
- R7: After the address byte 0xD3, the slave sends the register count (6 by default), then register 0, 1 and onward, MSB first. Once every register has been sent, it sends 0xFF.
- R8: When the master does not acknowledge a byte during a read, the slave stops transmitting, and the line stays released until the next start or stop.
- R9: `sda_oe` changes only while the synchronised serial clock is low, so the slave never disturbs the data line during a clock-high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | When 1, the open-drain driver pulls the data line low |
| regs_o | output | NREG*8 | Register contents, register k in bits 8k+7..8k |

## Verification
Every action follows a serial-clock edge. The edge passes through two synchroniser stages, then one edge-detect register, then the control state register. The slave's drive therefore changes about four system clocks after a serial-clock fall, and a register write shows on `regs_o` at the same point after the fall that ends the data byte. The bench master holds each serial-clock phase for ten system clocks. It samples the data line halfway through each high phase, and it reads `regs_o` only after a stop condition. At those points every result has settled well before it is read. Drive stability is checked by comparing `sda_oe` at the middle and at the end of each high phase.

// File: rtl/smb_ctl_pkg.sv
`timescale 1ns/1ps
package smb_ctl_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_RX_ACK,
      S_TX,
      S_TX_ACK,
      S_TX_NEXT,
      S_WAIT
   } smb_state_e;

   typedef enum logic [1:0] {
      P_ADDR,
      P_CMD,
      P_CNT,
      P_DATA
   } rx_phase_e;

   function automatic logic [7:0] reg_default(input int idx);
      case (idx)
         0:       return 8'h07;
         1:       return 8'hFF;
         2:       return 8'hFE;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_cond_detect.sv
`timescale 1ns/1ps
module smb_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_ctl_regfile.sv
`timescale 1ns/1ps
module smb_ctl_regfile
   import smb_ctl_pkg::*;
#(
   parameter int NREG  = 6,
   parameter int IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rd_data,
   output logic [NREG*8-1:0] regs_o
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  q <= reg_default(g);
         else if (wr_en && wr_idx == IDX_W'(g))       q <= wr_data;
      end
      assign regs_o[g*8 +: 8] = q;
   end

   always_comb begin
      rd_data = 8'hFF;
      for (int i = 0; i < NREG; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_o[i*8 +: 8];
      end
   end

   // R5: a write never targets an index beyond the register bank
   a_r5_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < IDX_W'(NREG)));
endmodule

// File: rtl/smb_ctl_slave.sv
`timescale 1ns/1ps
module smb_ctl_slave
   import smb_ctl_pkg::*;
#(
   parameter int         NREG        = 6,
   parameter int         MAX_WR      = 10,
   parameter logic [6:0] ADDR7       = 7'h69,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [NREG*8-1:0] regs_o
);
   localparam int         IDX_W    = $clog2(MAX_WR + 2);
   localparam logic [7:0] WR_ADDR  = {ADDR7, 1'b0};
   localparam logic [7:0] RD_ADDR  = {ADDR7, 1'b1};
   localparam logic [7:0] CNT_BYTE = 8'(NREG);

   if (NREG < 1 || NREG > 255) begin : g_bad_nreg
      $error("smb_ctl_slave: NREG out of range");
   end
   if (MAX_WR < NREG) begin : g_bad_maxwr
      $error("smb_ctl_slave: MAX_WR must cover every register");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   smb_cond_detect u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p));

   smb_state_e       state;
   rx_phase_e        phase;
   logic             is_read;
   logic [3:0]       bitcnt;
   logic [7:0]       shreg;
   logic [7:0]       txsh;
   logic [IDX_W-1:0] widx;
   logic [IDX_W-1:0] ridx;
   logic [7:0]       rd_data;
   logic             byte_done;
   logic             wr_en;

   assign byte_done = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
   assign wr_en     = byte_done && (phase == P_DATA) && !is_read &&
                      (widx < IDX_W'(NREG));

   smb_ctl_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(widx), .wr_data(shreg),
      .rd_idx(ridx), .rd_data(rd_data), .regs_o(regs_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         phase   <= P_ADDR;
         is_read <= 1'b0;
         bitcnt  <= '0;
         shreg   <= '0;
         txsh    <= '0;
         widx    <= '0;
         ridx    <= '0;
         sda_oe  <= 1'b0;
      end else if (stop_p) begin
         state  <= S_IDLE;
         sda_oe <= 1'b0;
      end else if (start_p) begin
         state   <= S_RX;
         phase   <= P_ADDR;
         is_read <= 1'b0;
         bitcnt  <= '0;
         widx    <= '0;
         ridx    <= '0;
         sda_oe  <= 1'b0;
      end else begin
         case (state)
            S_RX: begin
               if (scl_rise && bitcnt < 4'd8) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  case (phase)
                     P_ADDR: begin
                        if (shreg == WR_ADDR) begin
                           sda_oe <= 1'b1; state <= S_RX_ACK; phase <= P_CMD;
                        end else if (shreg == RD_ADDR) begin
                           sda_oe <= 1'b1; state <= S_RX_ACK; is_read <= 1'b1;
                        end else begin
                           state <= S_WAIT;
                        end
                     end
                     P_CMD: begin
                        sda_oe <= 1'b1; state <= S_RX_ACK; phase <= P_CNT;
                     end
                     P_CNT: begin
                        sda_oe <= 1'b1; state <= S_RX_ACK; phase <= P_DATA;
                     end
                     default: begin
                        if (widx < IDX_W'(MAX_WR)) begin
                           sda_oe <= 1'b1;
                           state  <= S_RX_ACK;
                           widx   <= widx + 1'b1;
                        end else begin
                           state <= S_WAIT;
                        end
                     end
                  endcase
               end
            end
            S_RX_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (is_read) begin
                     txsh   <= CNT_BYTE;
                     sda_oe <= ~CNT_BYTE[7];
                     state  <= S_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= S_RX;
                  end
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     state  <= S_TX_ACK;
                  end else begin
                     bitcnt <= bitcnt + 4'd1;
                     txsh   <= {txsh[6:0], 1'b0};
                     sda_oe <= ~txsh[6];
                  end
               end
            end
            S_TX_ACK: begin
               if (scl_rise) state <= sda_s ? S_WAIT : S_TX_NEXT;
            end
            S_TX_NEXT: begin
               if (scl_fall) begin
                  txsh   <= rd_data;
                  sda_oe <= ~rd_data[7];
                  if (ridx < IDX_W'(NREG)) ridx <= ridx + 1'b1;
                  state  <= S_TX;
               end
            end
            default: sda_oe <= 1'b0;
         endcase
      end
   end

   // R9: the slave's drive only moves while the synchronised clock is low
   a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);
   // R4: a slave that declined a transfer never drives the line
   a_r4_wait_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WAIT) |-> !sda_oe);
   // R6: the accepted data byte count never passes the write limit
   a_r6_widx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      widx <= IDX_W'(MAX_WR));
   // R2: a detected stop leaves the slave idle with the line released
   a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> (state == S_IDLE && !sda_oe));
   // R7: every transmitted byte ends with the line released for the master's acknowledge
   a_r7_release_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_TX_ACK) |-> !sda_oe);
endmodule

// File: tb/sim_smb_ctl_slave.sv
`timescale 1ns/1ps
module sim_smb_ctl_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 10;
   localparam int NREG       = 6;
   localparam int WD_LIMIT   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_line;
   logic sda_oe;
   logic [NREG*8-1:0] regs_o;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   smb_ctl_slave #(.NREG(NREG)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .regs_o(regs_o));

   // scoreboard
   logic [63:0] exp_q[$];
   logic [63:0] act_q[$];
   string       req_q[$];
   int n_checks = 0;
   int n_err    = 0;
   int viol     = 0;
   logic [7:0] model [NREG];
   logic [7:0] tx_buf [16];

   task automatic chk(input string r, input logic [63:0] a, input logic [63:0] e);
      req_q.push_back(r);
      exp_q.push_back(e);
      act_q.push_back(a);
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) begin
            logic [63:0] e, a;
            string r;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            r = req_q.pop_front();
            n_checks++;
            if (a !== e) begin
               n_err++;
               $display("FAIL %s: actual=%0h expected=%0h", r, a, e);
            end
         end
      end
   end

   function automatic logic [63:0] model_vec();
      logic [63:0] v = '0;
      for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
      return v;
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic samp);
      logic oe_a;
      m_sda = b;
      wait_clk(HALF);
      m_scl = 1'b1;
      wait_clk(HALF/2);
      samp = sda_line;
      oe_a = sda_oe;
      wait_clk(HALF/2);
      if (sda_oe !== oe_a) viol++;
      m_scl = 1'b0;
      wait_clk(3);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wait_clk(HALF);
      m_scl = 1'b1; wait_clk(HALF);
      m_sda = 1'b0; wait_clk(HALF);
      m_scl = 1'b0; wait_clk(3);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wait_clk(HALF);
      m_scl = 1'b1; wait_clk(HALF);
      m_sda = 1'b1; wait_clk(HALF);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic nack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      nack = s;
   endtask

   task automatic recv_byte(input logic mnack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(mnack, s);
   endtask

   // write transaction: address, command, count, then n data bytes from tx_buf
   task automatic wr_seq(input logic [7:0] addr, input int n, input bit do_stop);
      logic nk;
      bit ok = (addr == 8'hD2);
      bus_start();
      send_byte(addr, nk);
      chk(ok ? "R3 address ack" : "R4 address nack", 64'(nk), ok ? 64'd0 : 64'd1);
      send_byte(8'hA5, nk);
      chk(ok ? "R3 command ack" : "R4 silent", 64'(nk), ok ? 64'd0 : 64'd1);
      send_byte(8'h5A, nk);
      chk(ok ? "R3 count ack" : "R4 silent", 64'(nk), ok ? 64'd0 : 64'd1);
      for (int k = 0; k < n; k++) begin
         send_byte(tx_buf[k], nk);
         if (!ok)           chk("R4 data silent", 64'(nk), 64'd1);
         else if (k >= 10)  chk("R6 beyond limit nack", 64'(nk), 64'd1);
         else if (k >= NREG) chk("R6 excess acked", 64'(nk), 64'd0);
         else begin
            chk("R5 data ack", 64'(nk), 64'd0);
            model[k] = tx_buf[k];
         end
      end
      if (do_stop) bus_stop();
   endtask

   // read transaction: n bytes after the count, last one not acknowledged
   task automatic rd_seq(input int n, input bit extra);
      logic nk;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD3, nk);
      chk("R7 read address ack", 64'(nk), 64'd0);
      recv_byte(1'b0, b);
      chk("R7 count byte", 64'(b), 64'(NREG));
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n-1, b);
         chk("R7 register byte", 64'(b), (i < NREG) ? 64'(model[i]) : 64'hFF);
      end
      if (extra) begin
         recv_byte(1'b1, b);
         chk("R8 silent after nack", 64'(b), 64'hFF);
      end
      bus_stop();
   endtask

   bit done = 1'b0;

   initial begin : watchdog
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         n_err++;
         n_checks++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic nk;
      logic [7:0] b;
      model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'hFE;
      for (int i = 3; i < NREG; i++) model[i] = 8'h00;

      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      chk("R1 reset registers", 64'(regs_o), model_vec());
      chk("R1 line released", 64'(sda_oe), 64'd0);

      // R3/R5: three data bytes
      tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
      wr_seq(8'hD2, 3, 1'b1);
      chk("R5 registers after write", 64'(regs_o), model_vec());

      // R4: foreign addresses
      tx_buf[0] = 8'h00; tx_buf[1] = 8'h11;
      wr_seq(8'hA0, 2, 1'b1);
      chk("R4 registers unchanged", 64'(regs_o), model_vec());
      wr_seq(8'hD0, 2, 1'b1);
      chk("R4 registers unchanged near address", 64'(regs_o), model_vec());

      // R6: twelve data bytes
      for (int k = 0; k < 12; k++) tx_buf[k] = 8'h30 + 8'(k);
      wr_seq(8'hD2, 12, 1'b1);
      chk("R6 registers after long write", 64'(regs_o), model_vec());

      // R7/R8: short read with early nack, then full read running past the bank
      rd_seq(3, 1'b1);
      rd_seq(NREG + 1, 1'b0);

      // R2: repeated start in the middle of a write, then a read
      tx_buf[0] = 8'h11;
      wr_seq(8'hD2, 1, 1'b0);
      rd_seq(1, 1'b0);
      chk("R2 registers after repeated start", 64'(regs_o), model_vec());

      // R2: stop after command byte, new write restarts at register 0
      bus_start();
      send_byte(8'hD2, nk);
      chk("R2 address ack", 64'(nk), 64'd0);
      send_byte(8'hA5, nk);
      chk("R2 command ack", 64'(nk), 64'd0);
      bus_stop();
      chk("R2 line released after stop", 64'(sda_oe), 64'd0);
      tx_buf[0] = 8'h22; tx_buf[1] = 8'h44;
      wr_seq(8'hD2, 2, 1'b1);
      chk("R2 restart from register 0", 64'(regs_o), model_vec());

      // R8: nack on the count byte stops the transfer at once
      bus_start();
      send_byte(8'hD3, nk);
      recv_byte(1'b1, b);
      chk("R8 count then nack", 64'(b), 64'(NREG));
      recv_byte(1'b1, b);
      chk("R8 no drive after nack", 64'(b), 64'hFF);
      bus_stop();

      chk("R9 drive stable in clock-high phases", 64'(viol), 64'd0);

      wait_clk(10);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule